// File: doc/BRIEF.md
# Dual-Loop Lock Detector with Test-Select Status Pin

This block decides whether two phase-locked loops, a main loop and an auxiliary loop, are in lock, and drives one shared status pin. Each loop's phase-detector up and down outputs are watched over every reference window. A window is the span between two pulses of the divided reference, `ref_tick`. A loop counts as locked after a run of clean windows. The pin shows the AND of the two loop results. A loop whose enable input is low always counts as locked.

A 2-bit select register can turn the pin into a probe for the divider outputs. Each divider output keeps a fixed polarity on the pin, so its divide ratio can be measured from outside. The select register resets to the lock view, so the pin shows lock until software writes the register. Every input here is a plain level or pulse synchronous to `clk`, and there is no stream interface. The pin is registered, so changing the select never produces a glitch.

Top module: `pll_lock_mux`

## Requirements
- R1: In select 2'b00 the pin is high only when the main loop and the auxiliary loop are both locked or disabled.
- R2: A window is in range when the number of `clk` cycles with up or down asserted is below ERR_TOL (default 1). The cycle that carries `ref_tick` belongs to the window that this pulse closes.
- R3: A loop becomes locked on the `ref_tick` that closes its GOOD_N-th consecutive in-range window (default 4). In the lock view, the pin rises one clock after the loop flag.
- R4: A loop loses lock on the first `ref_tick` that closes an out-of-range window.
- R5: A loop whose enable is 0 counts as locked for R1. Its window history is cleared, so after it is enabled again it needs a fresh run of GOOD_N windows.
- R6: The select register loads `sel_din` only on a clock where `sel_wr` is 1. At reset it holds 2'b00. The codes are 00 = lock, 01 = reference divider, 10 = auxiliary divider, 11 = main divider.
- R7: In select 01 the pin idles low and is high for each cycle of `ref_tick`.
- R8: In select 10 the pin follows the inverse of `aux_div_pulse`, and in select 11 it follows the inverse of `main_div_pulse`. Both idle high and go low at terminal count.
- R9: The pin is a register and shows the selected source as sampled on the previous clock edge. A select write on edge k changes the pin's source starting with the value registered on edge k+1.
- R10: During reset the pin is low and both loop lock flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse from the reference divider; closes a window |
| main_div_pulse | input | 1 | One-cycle terminal-count pulse of the main divider |
| aux_div_pulse | input | 1 | One-cycle terminal-count pulse of the auxiliary divider |
| main_up | input | 1 | Main phase-detector up output |
| main_dn | input | 1 | Main phase-detector down output |
| aux_up | input | 1 | Auxiliary phase-detector up output |
| aux_dn | input | 1 | Auxiliary phase-detector down output |
| main_en | input | 1 | Main loop counter enable |
| aux_en | input | 1 | Auxiliary loop counter enable |
| sel_wr | input | 1 | Write strobe for the select register |
| sel_din | input | 2 | New select value |
| status_o | output | 1 | Shared lock / test status pin |

## Verification
The assertions assume that `ref_tick`, the divider pulses and the phase-detector signals are already synchronous to `clk` and change only between its edges. They also assume that reset is held long enough for every register to clear. The bench meets these assumptions by driving every input on the falling edge and releasing reset only after several clocks. The random phase spaces reference pulses several cycles apart and keeps phase errors rare, so that lock is gained and lost many times.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic [1:0] {
    SEL_LOCK = 2'b00,
    SEL_REF  = 2'b01,
    SEL_AUX  = 2'b10,
    SEL_MAIN = 2'b11
  } pin_sel_e;
endpackage

// File: rtl/lock_judge.sv
module lock_judge #(
  parameter int ERR_TOL = 1,
  parameter int GOOD_N  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic up,
  input  logic dn,
  output logic locked
);
  localparam int CW = $clog2(ERR_TOL + 1) + 1;
  localparam int GW = $clog2(GOOD_N + 1);
  localparam logic [CW-1:0] CAP = CW'(ERR_TOL);

  logic [CW-1:0] err_cnt, win_err, err_sat;
  logic [GW-1:0] good_cnt;
  logic          in_range;

  // error cycles in the current window, including this cycle
  always_comb begin
    win_err  = err_cnt + {{(CW-1){1'b0}}, (up | dn)};
    err_sat  = (win_err > CAP) ? CAP : win_err;
    in_range = (win_err < CAP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      err_cnt  <= '0;
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (tick) begin
      err_cnt <= '0;
      if (in_range) begin
        if (good_cnt != GW'(GOOD_N)) good_cnt <= good_cnt + 1'b1;
        locked <= (good_cnt >= GW'(GOOD_N - 1));
      end else begin
        good_cnt <= '0;
        locked   <= 1'b0;
      end
    end else begin
      err_cnt <= err_sat;
    end
  end

  AST_LOCK_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(tick)); // R3
  AST_LOCK_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_range)); // R2
  AST_DROP_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !in_range) |=> !locked); // R4
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !locked); // R5
endmodule

// File: rtl/sel_reg.sv
module sel_reg
  import pll_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] din,
  output pin_sel_e   sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  sel_q <= SEL_LOCK;
    else if (wr) sel_q <= pin_sel_e'(din);
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(sel_q)); // R6
endmodule

// File: rtl/status_mux.sv
module status_mux
  import pll_lock_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_sel_e sel,
  input  logic     lock_all,
  input  logic     ref_tick,
  input  logic     aux_pulse,
  input  logic     main_pulse,
  output logic     status_o
);
  logic pin_d;

  always_comb begin
    case (sel)
      SEL_LOCK: pin_d = lock_all;
      SEL_REF:  pin_d = ref_tick;
      SEL_AUX:  pin_d = ~aux_pulse;
      SEL_MAIN: pin_d = ~main_pulse;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_o <= 1'b0;
    else        status_o <= pin_d;
  end

  AST_REF_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) == SEL_REF && !$past(ref_tick)) |-> !status_o); // R7
  AST_AUX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) == SEL_AUX && !$past(aux_pulse)) |-> status_o); // R8
  AST_MAIN_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) == SEL_MAIN && !$past(main_pulse)) |-> status_o); // R8
endmodule

// File: rtl/pll_lock_mux.sv
module pll_lock_mux
  import pll_lock_pkg::*;
#(
  parameter int ERR_TOL = 1,
  parameter int GOOD_N  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       main_div_pulse,
  input  logic       aux_div_pulse,
  input  logic       main_up,
  input  logic       main_dn,
  input  logic       aux_up,
  input  logic       aux_dn,
  input  logic       main_en,
  input  logic       aux_en,
  input  logic       sel_wr,
  input  logic [1:0] sel_din,
  output logic       status_o
);
  localparam int NLOOP = 2;  // index 0 = main, 1 = aux

  logic [NLOOP-1:0] en_v, up_v, dn_v, lk_v, ok_v;
  logic             lock_all;
  pin_sel_e         sel_q;

  assign en_v = {aux_en, main_en};
  assign up_v = {aux_up, main_up};
  assign dn_v = {aux_dn, main_dn};

  for (genvar i = 0; i < NLOOP; i++) begin : g_loop
    lock_judge #(.ERR_TOL(ERR_TOL), .GOOD_N(GOOD_N)) u_judge (
      .clk(clk), .rst_n(rst_n), .en(en_v[i]), .tick(ref_tick),
      .up(up_v[i]), .dn(dn_v[i]), .locked(lk_v[i])
    );
    assign ok_v[i] = lk_v[i] | ~en_v[i];
  end

  assign lock_all = &ok_v;

  sel_reg u_sel (
    .clk(clk), .rst_n(rst_n), .wr(sel_wr), .din(sel_din), .sel_q(sel_q)
  );

  status_mux u_mux (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .lock_all(lock_all),
    .ref_tick(ref_tick), .aux_pulse(aux_div_pulse),
    .main_pulse(main_div_pulse), .status_o(status_o)
  );

  AST_BOTH_LOOPS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o && $past(sel_q) == SEL_LOCK) |-> ($past(ok_v[0]) && $past(ok_v[1]))); // R1
  AST_RESET_LOW: assert property (@(posedge clk)
    !$past(rst_n) |-> !status_o); // R10
endmodule

// File: tb/sim_pll_lock_mux.sv
module sim_pll_lock_mux;
  localparam int TOL = 1;
  localparam int RUN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 0, main_pulse = 0, aux_pulse = 0;
  logic main_up = 0, main_dn = 0, aux_up = 0, aux_dn = 0;
  logic main_en = 0, aux_en = 0, sel_wr = 0;
  logic [1:0] sel_in = 2'b00;
  logic status_o;

  always #4 clk = ~clk;  // 125 MHz

  pll_lock_mux #(.ERR_TOL(TOL), .GOOD_N(RUN)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .main_div_pulse(main_pulse), .aux_div_pulse(aux_pulse),
    .main_up(main_up), .main_dn(main_dn), .aux_up(aux_up), .aux_dn(aux_dn),
    .main_en(main_en), .aux_en(aux_en), .sel_wr(sel_wr), .sel_din(sel_in),
    .status_o(status_o)
  );

  int errors = 0;
  int checks = 0;
  string cur_req = "R10";

  typedef struct { logic val; string req; } exp_t;
  exp_t sb[$];

  // requirement model
  int m_cnt[2];
  int m_good[2];
  bit m_lk[2];
  logic [1:0] m_sel;

  task automatic m_upd(int i, bit en, bit err);
    int w;
    if (!en) begin
      m_cnt[i] = 0; m_good[i] = 0; m_lk[i] = 0;
    end else begin
      w = m_cnt[i] + (err ? 1 : 0);
      if (ref_tick) begin
        m_cnt[i] = 0;
        if (w < TOL) begin
          if (m_good[i] < RUN) m_good[i]++;
          m_lk[i] = (m_good[i] >= RUN);
        end else begin
          m_good[i] = 0; m_lk[i] = 0;
        end
      end else begin
        m_cnt[i] = (w > TOL) ? TOL : w;
      end
    end
  endtask

  always @(posedge clk) begin : mdl
    logic pin;
    if (!rst_n) begin
      m_cnt = '{0, 0}; m_good = '{0, 0}; m_lk = '{0, 0}; m_sel = 2'b00;
      sb.delete();
    end else begin
      case (m_sel)
        2'b00:   pin = (m_lk[0] || !main_en) && (m_lk[1] || !aux_en);
        2'b01:   pin = ref_tick;
        2'b10:   pin = !aux_pulse;
        default: pin = !main_pulse;
      endcase
      sb.push_back('{pin, cur_req});
      if (sel_wr) m_sel = sel_in;
      m_upd(0, main_en, main_up | main_dn);
      m_upd(1, aux_en, aux_up | aux_dn);
    end
  end

  task automatic check(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: status_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && sb.size() > 0) begin
      e = sb.pop_front();
      check(status_o, e.val, e.req);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic windows(int n, int per);
    for (int k = 0; k < n; k++) begin
      ref_tick = 1; step(1);
      ref_tick = 0; step(per - 1);
    end
  endtask

  task automatic write_sel(logic [1:0] v);
    sel_wr = 1; sel_in = v; step(1);
    sel_wr = 0; sel_in = ~v;  // differing data without strobe must be ignored
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: run=timeout expected=finish");
    report();
  end

  initial begin
    step(3);
    check(status_o, 1'b0, "R10");  // reset state
    rst_n = 1;
    // both loops disabled: counted as locked
    cur_req = "R5"; step(4);
    check(status_o, 1'b1, "R5");
    // main enabled, clean windows: lock after RUN ticks
    cur_req = "R3"; main_en = 1; step(1);
    windows(6, 6);
    // one error cycle drops lock at next tick
    cur_req = "R4"; main_up = 1; step(1); main_up = 0; step(2);
    windows(3, 6);
    // error in the tick cycle counts toward the closing window
    cur_req = "R2"; windows(5, 6);
    ref_tick = 1; main_dn = 1; step(1); ref_tick = 0; main_dn = 0; step(5);
    windows(5, 6);
    // aux enabled but erroring: combined lock low; then both lock
    cur_req = "R1"; aux_en = 1; aux_up = 1; windows(4, 6);
    aux_up = 0; aux_dn = 1; step(1); aux_dn = 0; windows(6, 6);
    // disable/re-enable aux clears its history
    cur_req = "R5"; aux_en = 0; step(3); aux_en = 1; windows(5, 6);
    // select register and reference view
    cur_req = "R6"; write_sel(2'b01); step(2);
    cur_req = "R7"; windows(4, 5);
    cur_req = "R8"; write_sel(2'b10);
    for (int k = 0; k < 20; k++) begin
      aux_pulse = (k % 5 == 0); main_pulse = (k % 3 == 0); step(1);
    end
    write_sel(2'b11);
    for (int k = 0; k < 20; k++) begin
      main_pulse = (k % 4 == 0); aux_pulse = (k % 3 == 0); step(1);
    end
    aux_pulse = 0; main_pulse = 0;
    // rapid select changes while pulses and ticks are active
    cur_req = "R9";
    for (int k = 0; k < 40; k++) begin
      sel_wr = (k % 3 != 2); sel_in = 2'(k);
      ref_tick = (k % 2 == 0); aux_pulse = (k % 3 == 0); main_pulse = (k % 5 == 1);
      step(1);
    end
    sel_wr = 0; ref_tick = 0; aux_pulse = 0; main_pulse = 0;
    write_sel(2'b00); step(2);
    // mixed random traffic
    cur_req = "R1";
    for (int k = 0; k < 4000; k++) begin
      ref_tick   = (k % 6 == 0);
      main_up    = ($urandom % 40 == 0);
      aux_dn     = ($urandom % 40 == 0);
      main_pulse = ($urandom % 7 == 0);
      aux_pulse  = ($urandom % 9 == 0);
      if ($urandom % 300 == 0) main_en = ~main_en;
      if ($urandom % 300 == 0) aux_en = ~aux_en;
      sel_wr = ($urandom % 200 == 0); sel_in = 2'($urandom);
      step(1);
    end
    ref_tick = 0; main_up = 0; aux_dn = 0; sel_wr = 0;
    step(3);
    report();
  end
endmodule